// File: doc/BRIEF.md
# Resistive-Majority In-Memory Executor

This block is a small compute engine with one operation and no registers. A data memory of 64-bit words holds every operand and every result. Each instruction names a source A, a source B and a destination Z. The engine writes back into Z the majority of A, the inverse of B, and the old contents of Z. Either source may be a literal 0 or 1 in place of a memory location. A mode bit chooses between two forms. The word form runs on all 64 lanes of three whole words. The bit form runs on single bits, each addressed as a word index plus a bit offset. Because the offsets are independent, the bit form can move a bit from one position to another. This is how carry chains are built. Every address is fixed in the instruction, and no address is ever taken from memory contents.

Programs are loaded into a separate instruction memory through a write port. A `start` pulse runs the program from address zero. Each instruction passes through three states. ST_FETCH latches the instruction. ST_READ captures both sources and the old destination word. ST_WRITE stores the result and advances the program counter, then returns to ST_FETCH.

The other states and transitions are these. ST_IDLE holds after reset until `start`. A fetched halt instruction moves to ST_HALT, which holds the program counter and raises `done`. `start` in any state forces ST_FETCH with the counter at zero. A read-only debug port shows any data word at all times. AND, XOR and full addition are composed in software from sequences of this single operation.

Top module: `mj_executor`

## Requirements
- R1: An instruction is 55 bits wide, laid out as follows:
  - [54:53] opcode, where 11 means halt and any other value executes;
  - [52] form, where 1 means word and 0 means bit;
  - [51] literal flag for A and [50] literal value for A;
  - [49] literal flag for B and [48] literal value for B;
  - [47:32] location of A, [31:16] location of B, [15:0] location of Z.
  
  Each location holds a 10-bit word index in its upper bits and a 6-bit bit offset in its lower bits.
- R2: In the word form, each bit i of Z becomes (a_i AND NOT b_i) OR (NOT b_i AND z_i) OR (a_i AND z_i), where z_i is the old value of Z.
- R3: In the bit form, only the bit at Z's offset changes. It takes the same function applied to A's bit at A's offset, B's bit at B's offset and the old Z bit. The three offsets are independent, and the other 63 bits of Z keep their values.
- R4: A literal source acts as its value on every lane. The results follow from the function:
  - A=0 with B=1 clears the destination;
  - A=1 with B=0 sets the destination;
  - A=1 over a cleared destination stores the inverse of B.
- R5: Only the destination word is written, and the source words keep their contents.
- R6: Each executed instruction takes exactly three cycles. With N instructions before the halt, `done` rises on the (3N+1)-th rising edge after the edge that samples `start`.
- R7: A halt opcode raises `done` and freezes the program counter. Instructions placed after the halt are never executed, and `done` stays high until the next `start`.
- R8: `start` clears `done` and restarts the program at instruction address 0, from any state.
- R9: After reset, `done` is low and nothing executes until `start`.
- R10: A four-step sequence (clear, clear, inverse copy, combine) leaves A AND B in the destination.
- R11: A bit-form carry chain followed by two word-form XORs computes the 64-bit sum of two words modulo 2^64. This includes a carry that travels through all 64 positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart the program from address 0 and clear `done` |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | 9 | Instruction memory write address |
| imem_wdata | input | 55 | Instruction word to store |
| dbg_idx | input | 10 | Data word index for the debug read |
| dbg_data | output | 64 | Contents of the data word at `dbg_idx` |
| done | output | 1 | High while the program is halted |

## Verification
Several properties are checked on every cycle:
- data memory writes are at least three cycles apart;
- a bit-form write changes at most one bit of the destination word;
- a halt never reaches the read state;
- while `done` is high, `done` and the program counter hold and no write occurs;
- `start` clears `done` and zeroes the counter on the next cycle.

Other behaviours can only be shown by running scenarios and reading back memory:
- the value each form computes;
- the literal-operand identities;
- that the source words stay unchanged;
- the exact cycle at which `done` rises;
- that instructions after a halt are skipped;
- the composed AND and the 64-bit ripple sum, including a carry through every position.

// File: rtl/mj_pkg.sv
`timescale 1ns/1ps
package mj_pkg;
    localparam int LANES  = 64;
    localparam int WIDX_W = 10;
    localparam int BOFF_W = $clog2(LANES);

    typedef logic [LANES-1:0] mj_word_t;

    // operand location: word index above, bit offset below
    typedef struct packed {
        logic [WIDX_W-1:0] widx;
        logic [BOFF_W-1:0] boff;
    } mj_loc_t;

    typedef struct packed {
        logic [1:0] op;
        logic       word_mode;
        logic       a_lit;
        logic       a_val;
        logic       b_lit;
        logic       b_val;
        mj_loc_t    a_loc;
        mj_loc_t    b_loc;
        mj_loc_t    z_loc;
    } mj_instr_t;

    localparam int         INSTR_W = $bits(mj_instr_t);
    localparam logic [1:0] OP_STOP = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_HALT
    } mj_state_e;

    // majority of a, inverted b and the old destination bit
    function automatic logic rmaj(input logic a, input logic b, input logic z);
        return (a & ~b) | (~b & z) | (a & z);
    endfunction
endpackage

// File: rtl/mj_imem.sv
`timescale 1ns/1ps
module mj_imem
    import mj_pkg::*;
#(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      we,
    input  logic [AW-1:0] waddr,
    input  mj_instr_t wdata,
    input  logic [AW-1:0] raddr,
    output mj_instr_t rdata
);
    mj_instr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mj_dmem.sv
`timescale 1ns/1ps
module mj_dmem
    import mj_pkg::*;
#(
    parameter  int WORDS = 1024,
    parameter  int NRD   = 4,
    localparam int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  mj_word_t      w_data,
    input  logic [IW-1:0] rd_idx  [NRD],
    output mj_word_t      rd_data [NRD]
);
    mj_word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[w_idx] <= w_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_idx[p]];
    end
endmodule

// File: rtl/mj_rmaj_unit.sv
`timescale 1ns/1ps
module mj_rmaj_unit
    import mj_pkg::*;
(
    input  mj_word_t          op_a,
    input  mj_word_t          op_b,
    input  mj_word_t          op_z,
    input  logic              word_mode,
    input  logic [BOFF_W-1:0] a_off,
    input  logic [BOFF_W-1:0] b_off,
    input  logic [BOFF_W-1:0] z_off,
    output mj_word_t          result
);
    logic bit_r;

    assign bit_r = rmaj(op_a[a_off], op_b[b_off], op_z[z_off]);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign result[g] = word_mode ? rmaj(op_a[g], op_b[g], op_z[g])
                         : ((z_off == BOFF_W'(g)) ? bit_r : op_z[g]);
    end
endmodule

// File: rtl/mj_executor.sv
`timescale 1ns/1ps
module mj_executor
    import mj_pkg::*;
#(
    parameter  int IMEM_DEPTH = 512,
    parameter  int DMEM_WORDS = 1024,
    localparam int PC_W       = $clog2(IMEM_DEPTH),
    localparam int DI_W       = $clog2(DMEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               imem_we,
    input  logic [PC_W-1:0]    imem_waddr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic [DI_W-1:0]    dbg_idx,
    output logic [LANES-1:0]   dbg_data,
    output logic               done
);
    mj_state_e        state, nstate;
    logic [PC_W-1:0]  pc;
    mj_instr_t        ir, fetched;
    mj_word_t         op_a, op_b, op_z, wr_word;
    logic             dmem_we;
    logic [DI_W-1:0]  rd_idx  [4];
    mj_word_t         rd_data [4];

    mj_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (mj_instr_t'(imem_wdata)),
        .raddr (pc),
        .rdata (fetched)
    );

    assign rd_idx[0] = ir.a_loc.widx[DI_W-1:0];
    assign rd_idx[1] = ir.b_loc.widx[DI_W-1:0];
    assign rd_idx[2] = ir.z_loc.widx[DI_W-1:0];
    assign rd_idx[3] = dbg_idx;
    assign dbg_data  = rd_data[3];

    mj_dmem #(.WORDS(DMEM_WORDS), .NRD(4)) u_dmem (
        .clk     (clk),
        .we      (dmem_we),
        .w_idx   (ir.z_loc.widx[DI_W-1:0]),
        .w_data  (wr_word),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    mj_rmaj_unit u_rmaj (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_z      (op_z),
        .word_mode (ir.word_mode),
        .a_off     (ir.a_loc.boff),
        .b_off     (ir.b_loc.boff),
        .z_off     (ir.z_loc.boff),
        .result    (wr_word)
    );

    assign dmem_we = (state == ST_WRITE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  nstate = ST_IDLE;
            ST_FETCH: nstate = (fetched.op == OP_STOP) ? ST_HALT : ST_READ;
            ST_READ:  nstate = ST_WRITE;
            ST_WRITE: nstate = ST_FETCH;
            ST_HALT:  nstate = ST_HALT;
        endcase
        if (start) begin
            nstate = ST_FETCH;
        end
    end

    // datapath registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc   <= '0;
            done <= 1'b0;
            ir   <= '0;
            op_a <= '0;
            op_b <= '0;
            op_z <= '0;
        end else if (start) begin
            pc   <= '0;
            done <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir <= fetched;
                    if (fetched.op == OP_STOP) begin
                        done <= 1'b1;
                    end
                end
                ST_READ: begin
                    op_a <= ir.a_lit ? {LANES{ir.a_val}} : rd_data[0];
                    op_b <= ir.b_lit ? {LANES{ir.b_val}} : rd_data[1];
                    op_z <= rd_data[2];
                end
                ST_WRITE: pc <= pc + 1'b1;
                default: ;
            endcase
        end
    end

    // R6
    wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (!$past(dmem_we) && !$past(dmem_we, 2)));

    // R3
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && !ir.word_mode) |-> ($countones(wr_word ^ op_z) <= 1));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pc)));

    // R7
    halt_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dmem_we);

    // R7
    halt_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |-> (ir.op != OP_STOP));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && pc == '0));
endmodule

// File: tb/mj_executor_test.sv
`timescale 1ns/1ps
module mj_executor_test;
    logic        clk = 1'b0;
    logic        rst_n, start, imem_we;
    logic [8:0]  imem_waddr;
    logic [54:0] imem_wdata;
    logic [9:0]  dbg_idx;
    logic [63:0] dbg_data;
    logic        done;

    always #2.5 clk = ~clk;

    mj_executor uut (
        .clk(clk), .rst_n(rst_n), .start(start), .imem_we(imem_we),
        .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .done(done)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    int   prog_len = 0;
    logic done_after_start;

    typedef struct packed {
        logic [3:0]  req;
        logic        wm, ac, av, bc, bv;
        logic [5:0]  ao, bo, zo;
        logic [63:0] a, b, z;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0,
          64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC, 64'hAAAA_AAAA_AAAA_AAAA},
        '{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0,
          64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_00FF_F0F0_FF00},
        '{4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd0, 6'd0, 6'd0,
          64'h0, 64'h0, 64'hDEAD_BEEF_CAFE_F00D},
        '{4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0,
          64'h0, 64'h00FF_00FF_1234_5678, 64'h0},
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd5, 6'd0, 6'd17,
          64'h20, 64'h0, 64'h5555_5555_5555_5555},
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd10, 6'd40, 6'd63,
          64'h400, 64'h0, 64'h7FFF_FFFF_FFFF_FFFF},
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd63, 6'd0, 6'd0,
          64'h8000_0000_0000_0000, 64'h1, 64'hFFFF_0000_0000_0001},
        '{4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd0, 6'd0, 6'd31,
          64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    localparam logic [54:0] HALT_I = {2'b11, 53'd0};

    // R1: instruction layout used to build every program
    function automatic logic [54:0] mk(input logic wm, input logic al, input logic av,
                                       input logic bl, input logic bv,
                                       input int aw, input int ab, input int bw,
                                       input int bb, input int zw, input int zb);
        return {2'b00, wm, al, av, bl, bv, aw[9:0], ab[5:0], bw[9:0], bb[5:0],
                zw[9:0], zb[5:0]};
    endfunction

    function automatic logic [63:0] ref_maj(input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] z);
        return (a & ~b) | (~b & z) | (a & z);
    endfunction

    function automatic logic [63:0] ref_vec(input vec_t v);
        logic [63:0] aw, bw, r;
        logic        br;
        aw = v.ac ? {64{v.av}} : v.a;
        bw = v.bc ? {64{v.bv}} : v.b;
        if (v.wm) begin
            r = ref_maj(aw, bw, v.z);
        end else begin
            br = (aw[v.ao] & ~bw[v.bo]) | (~bw[v.bo] & v.z[v.zo]) | (aw[v.ao] & v.z[v.zo]);
            r = v.z;
            r[v.zo] = br;
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [54:0] ins);
        @(negedge clk);
        imem_we    = 1'b1;
        imem_waddr = prog_len[8:0];
        imem_wdata = ins;
        prog_len++;
    endtask

    task automatic clr_word(input int w); emit(mk(1, 1, 0, 1, 1, 0, 0, 0, 0, w, 0)); endtask
    task automatic set_word(input int w); emit(mk(1, 1, 1, 1, 0, 0, 0, 0, 0, w, 0)); endtask
    task automatic set_bit(input int w, input int b); emit(mk(0, 1, 1, 1, 0, 0, 0, 0, 0, w, b)); endtask
    task automatic clr_bit(input int w, input int b); emit(mk(0, 1, 0, 1, 1, 0, 0, 0, 0, w, b)); endtask
    task automatic inv_word(input int s, input int d); emit(mk(1, 1, 1, 0, 0, 0, 0, s, 0, d, 0)); endtask
    task automatic maj_w(input int x, input int y, input int d); emit(mk(1, 0, 0, 0, 0, x, 0, y, 0, d, 0)); endtask

    task automatic load_word(input int w, input logic [63:0] v);
        clr_word(w);
        for (int i = 0; i < 64; i++) begin
            if (v[i]) set_bit(w, i);
        end
    endtask

    // d = x XOR y using scratch words 7, 8, 9
    task automatic xor_prog(input int x, input int y, input int d);
        clr_word(7);  maj_w(x, y, 7);
        clr_word(8);  maj_w(y, x, 8);
        clr_word(9);  inv_word(8, 9);
        set_word(d);  maj_w(7, 9, d);
    endtask

    task automatic run_prog(input bit add_halt, output int cyc);
        if (add_halt) emit(HALT_I);
        @(negedge clk);
        imem_we = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        done_after_start = done;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 program timeout actual=%0d expected=done", cyc);
        end
        prog_len = 0;
    endtask

    task automatic rd(input int w, output logic [63:0] d);
        dbg_idx = w[9:0];
        #0.5;
        d = dbg_data;
    endtask

    initial begin
        #(750000.0);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int          cyc;
        logic [63:0] got;
        rst_n = 1'b0; start = 1'b0; imem_we = 1'b0;
        imem_waddr = '0; imem_wdata = '0; dbg_idx = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: idle after reset
        chk(done == 1'b0, "R9 done after reset", {63'd0, done}, 64'd0);
        repeat (10) @(negedge clk);
        chk(done == 1'b0, "R9 done stays low without start", {63'd0, done}, 64'd0);

        // vector table: one instruction per vector (R2, R3, R4, R5)
        for (int k = 0; k < NV; k++) begin
            load_word(1, VECS[k].a);
            load_word(2, VECS[k].b);
            load_word(3, VECS[k].z);
            emit(mk(VECS[k].wm, VECS[k].ac, VECS[k].av, VECS[k].bc, VECS[k].bv,
                    1, VECS[k].ao, 2, VECS[k].bo, 3, VECS[k].zo));
            run_prog(1'b1, cyc);
            rd(3, got);
            chk(got == ref_vec(VECS[k]), $sformatf("R%0d vector %0d result", VECS[k].req, k),
                got, ref_vec(VECS[k]));
            rd(1, got);
            chk(got == VECS[k].a, $sformatf("R5 vector %0d source A kept", k), got, VECS[k].a);
            rd(2, got);
            chk(got == VECS[k].b, $sformatf("R5 vector %0d source B kept", k), got, VECS[k].b);
        end

        // R6: two instructions then halt -> done on 7th edge
        clr_word(12);
        set_bit(12, 3);
        run_prog(1'b1, cyc);
        chk(cyc == 7, "R6 cycles to done", 64'(cyc), 64'd7);
        rd(12, got);
        chk(got == 64'h8, "R4 literal set bit", got, 64'h8);

        // R7: instruction after halt is skipped
        clr_word(13);
        emit(HALT_I);
        set_word(13);
        run_prog(1'b1, cyc);
        chk(cyc == 4, "R7 halt position", 64'(cyc), 64'd4);
        rd(13, got);
        chk(got == 64'h0, "R7 after-halt instruction skipped", got, 64'h0);
        repeat (40) @(negedge clk);
        chk(done == 1'b1, "R7 done held", {63'd0, done}, 64'd1);

        // R8: restart the same program from address 0
        prog_len = 4;
        run_prog(1'b0, cyc);
        chk(done_after_start == 1'b0, "R8 done cleared by start", {63'd0, done_after_start}, 64'd0);
        chk(cyc == 4, "R8 rerun from address 0", 64'(cyc), 64'd4);

        // R10: four-step AND
        load_word(1, 64'hA5A5_0F0F_FFFF_1234);
        load_word(2, 64'h3C3C_FF00_00FF_F0F0);
        clr_word(11);
        clr_word(5);
        inv_word(2, 5);
        maj_w(1, 5, 11);
        run_prog(1'b1, cyc);
        rd(11, got);
        chk(got == (64'hA5A5_0F0F_FFFF_1234 & 64'h3C3C_FF00_00FF_F0F0), "R10 AND result",
            got, 64'hA5A5_0F0F_FFFF_1234 & 64'h3C3C_FF00_00FF_F0F0);

        // R11: ripple additions
        for (int t = 0; t < 2; t++) begin
            logic [63:0] x, y;
            x = (t == 0) ? 64'h8F3C_A5E1_7B20_4D96 : 64'hFFFF_FFFF_FFFF_FFFF;
            y = (t == 0) ? 64'h7AC1_33FE_9402_BB6D : 64'h1;
            load_word(1, x);
            load_word(2, y);
            clr_word(4);
            clr_word(5);
            inv_word(2, 5);
            for (int i = 0; i < 63; i++) begin
                clr_bit(6, 0);
                emit(mk(0, 1, 1, 0, 0, 0, 0, 4, i, 6, 0));
                emit(mk(0, 1, 1, 0, 0, 0, 0, 6, 0, 4, i + 1));
                emit(mk(0, 0, 0, 0, 0, 1, i, 5, i, 4, i + 1));
            end
            xor_prog(1, 2, 10);
            xor_prog(10, 4, 3);
            run_prog(1'b1, cyc);
            rd(3, got);
            chk(got == x + y, $sformatf("R11 sum case %0d", t), got, x + y);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule